// File: doc/BRIEF.md
# I2C Slave Byte Engine with Software Handshake

This block is the bus side of an I2C slave that moves one byte at a time and hands every decision to software through one status/control register. It watches the clock and data lines through a synchronizer. It finds START, repeated START and STOP conditions. It shifts received bits into the data register, or shifts the data register out onto the data line. At fixed points in each byte it raises a byte-complete flag and an interrupt.

Software reads the received address or data and decides whether to acknowledge. It picks the direction of the next byte and loads transmit data. The hardware does not compare addresses. When software has not answered by the next falling clock edge after a byte completes, the block holds the clock line low until the control register is written. Both lines are open-drain: the block only pulls them low or lets them go.

Top module: `i2c_byte_slave`

## Requirements
- R1: A START (data falling while clock is high) clears transmit (bit 2), last-received-bit (bit 1) and byte-complete (bit 0), and starts reception of an address byte, whatever the transmit bit says.
- R2: After the eighth clock rise of an address byte, byte-complete (bit 0) and address (bit 3) are 1. The data register (select 0) holds the byte, first bit in the MSB. irq_o is high while byte-complete is 1.
- R3: On the ninth clock after a received byte, the slave pulls data low when ack-out (bit 4) was written 1 and releases it when it was written 0. Ack-out reads 0 after each new byte-complete.
- R4: If the control register (select 1) is not written before the clock falls after byte-complete, scl_low_o holds the clock low. The next control write releases it. A control write made while the clock is still high prevents the hold.
- R5: After an acknowledged address with transmit 0, the next byte is received. Byte-complete sets after its eighth bit, and the data register holds it.
- R6: With transmit 1 written at the acknowledge, the data register is sent MSB first, and the slave's data output changes only while the clock is low. Byte-complete sets at the ninth clock rise, and bit 1 holds the master's acknowledge (0 = ACK, 1 = NACK).
- R7: After a master NACK, the next control write, whatever its value, returns the engine to idle. The data line stays released and no byte-complete sets until a new START.
- R8: After software NACKs an address, no byte-complete or interrupt occurs until an address that follows the next START.
- R9: A STOP (data rising while clock is high) sets stop status (bit 5). Writing 0 to bit 5 clears it only while byte-complete is 1. irq_o is also high while stop status and stop_irq_en_i are both 1.
- R10: A START or STOP after two or more bits of a byte sets bus error (bit 7). Only a control write with bit 7 = 0 clears it. Bits 7, 5, 3, 1 and 0 are cleared by writing 0 and kept by writing 1; bits 4 and 2 take the written value. Bit 6 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen on the pin |
| sda_i | input | 1 | Bus data line as seen on the pin |
| scl_low_o | output | 1 | 1 pulls the clock line low (stretch) |
| sda_low_o | output | 1 | 1 pulls the data line low |
| reg_we_i | input | 1 | Register write strobe |
| reg_sel_i | input | 1 | 0 selects the data register, 1 the status/control register |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Read data of the selected register |
| stop_irq_en_i | input | 1 | Lets stop status raise the interrupt |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench builds the engine with a three-stage synchronizer instead of the default two. This stretches the delay between a line change and its event, and shows that the quarter-bit spacing of the bench master still leaves room for the stretch to engage before the master's next rising edge. With that latency, the bench covers both an answer before the falling edge, which gives no stretch, and a late answer, which gives a stretch. It also covers transmit bytes checked through a scoreboard, address NACK, master NACK and a misplaced START.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;

    localparam int BYTE_W = 8;
    localparam int CNT_W  = $clog2(BYTE_W + 1);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);
    localparam logic [CNT_W-1:0] ACK_SLOT = CNT_W'(BYTE_W);
    localparam logic [CNT_W-1:0] LATE_CNT = CNT_W'(2);

    // status/control bit positions
    localparam int B_BERR = 7;
    localparam int B_STOP = 5;
    localparam int B_ACK  = 4;
    localparam int B_ADR  = 3;
    localparam int B_TX   = 2;
    localparam int B_LRB  = 1;
    localparam int B_BC   = 0;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_RXHOLD,
        ST_RXACK,
        ST_TX,
        ST_TXHOLD,
        ST_IGNORE
    } eng_st_e;

    typedef struct packed {
        eng_st_e           st;
        logic [BYTE_W-1:0] dat;
        logic [CNT_W-1:0]  cnt;
        logic              in_addr;
        logic              ninth;
        logic              stretch;
        logic              sda_low;
        logic              berr;
        logic              stop;
        logic              ack;
        logic              adr;
        logic              tx;
        logic              lrb;
        logic              bc;
    } eng_s;

endpackage

// File: rtl/i2cs_sync.sv
module i2cs_sync #(
    parameter int STAGES = 2,
    parameter int W      = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    logic [W-1:0] stg_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg_q[i] <= '1;
        end else begin
            stg_q[0] <= async_i;
            for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
        end
    end

    assign sync_o = stg_q[STAGES-1];
endmodule

// File: rtl/i2cs_line_events.sv
module i2cs_line_events (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_evt,
    output logic stop_evt
);
    logic scl_d, scl_q, sda_d, sda_q;

    always_comb begin
        scl_d = scl_s;
        sda_d = sda_s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_d;
            sda_q <= sda_d;
        end
    end

    assign scl_rise  = scl_s & ~scl_q;
    assign scl_fall  = ~scl_s & scl_q;
    assign start_evt = scl_s & scl_q & sda_q & ~sda_s;
    assign stop_evt  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2c_byte_slave.sv
module i2c_byte_slave
    import i2cs_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       scl_low_o,
    output logic       sda_low_o,
    input  logic       reg_we_i,
    input  logic       reg_sel_i,
    input  logic [7:0] reg_wdata_i,
    output logic [7:0] reg_rdata_o,
    input  logic       stop_irq_en_i,
    output logic       irq_o
);
    logic [1:0] line_s;
    logic       scl_s, sda_s;
    logic       scl_rise, scl_fall, start_evt, stop_evt;
    eng_s       eng_d, eng_q;
    logic       ctl_wr, dat_wr, late_cond, drive_want;
    logic [7:0] stat_byte;
    logic       unused_wbit;

    assign unused_wbit = reg_wdata_i[6];

    i2cs_sync #(.STAGES(SYNC_STAGES), .W(2)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({scl_i, sda_i}),
        .sync_o  (line_s)
    );

    assign scl_s = line_s[1];
    assign sda_s = line_s[0];

    i2cs_line_events u_evt (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_evt (start_evt),
        .stop_evt  (stop_evt)
    );

    always_comb begin
        eng_d  = eng_q;
        ctl_wr = reg_we_i & reg_sel_i;
        dat_wr = reg_we_i & ~reg_sel_i;

        // software side of the handshake
        if (dat_wr) eng_d.dat = reg_wdata_i;
        if (ctl_wr) begin
            if (!reg_wdata_i[B_BERR]) eng_d.berr = 1'b0;
            if (!reg_wdata_i[B_STOP] && eng_q.bc) eng_d.stop = 1'b0;
            eng_d.ack = reg_wdata_i[B_ACK];
            if (!reg_wdata_i[B_ADR]) eng_d.adr = 1'b0;
            eng_d.tx = reg_wdata_i[B_TX];
            if (!reg_wdata_i[B_LRB]) eng_d.lrb = 1'b0;
            if (!reg_wdata_i[B_BC])  eng_d.bc  = 1'b0;
        end

        // bus side, hardware events take priority over the write
        case (eng_q.st)
            ST_RX: begin
                if (scl_rise) begin
                    eng_d.dat = {eng_q.dat[BYTE_W-2:0], sda_s};
                    eng_d.cnt = eng_q.cnt + 1'b1;
                    if (eng_q.cnt == LAST_BIT) begin
                        eng_d.bc    = 1'b1;
                        eng_d.ack   = 1'b0;
                        eng_d.ninth = 1'b0;
                        if (eng_q.in_addr) eng_d.adr = 1'b1;
                        eng_d.st    = ST_RXHOLD;
                    end
                end
            end
            ST_RXHOLD: begin
                if (ctl_wr) begin
                    eng_d.stretch = 1'b0;
                    eng_d.ninth   = 1'b0;
                    eng_d.st      = ST_RXACK;
                end else if (scl_fall) begin
                    eng_d.stretch = 1'b1;
                end
            end
            ST_RXACK: begin
                if (scl_rise) begin
                    eng_d.ninth = 1'b1;
                end else if (scl_fall && eng_q.ninth) begin
                    eng_d.cnt     = '0;
                    eng_d.in_addr = 1'b0;
                    if (!eng_q.ack)     eng_d.st = ST_IGNORE;
                    else if (eng_q.tx)  eng_d.st = ST_TX;
                    else                eng_d.st = ST_RX;
                end
            end
            ST_TX: begin
                if (scl_rise) begin
                    if (eng_q.cnt == ACK_SLOT) begin
                        eng_d.lrb = sda_s;
                        eng_d.bc  = 1'b1;
                        eng_d.ack = 1'b0;
                        eng_d.st  = ST_TXHOLD;
                    end else begin
                        eng_d.dat = {eng_q.dat[BYTE_W-2:0], sda_s};
                        eng_d.cnt = eng_q.cnt + 1'b1;
                    end
                end
            end
            ST_TXHOLD: begin
                if (ctl_wr) begin
                    eng_d.stretch = 1'b0;
                    eng_d.cnt     = '0;
                    if (eng_q.lrb)                 eng_d.st = ST_IDLE;
                    else if (reg_wdata_i[B_TX])    eng_d.st = ST_TX;
                    else                           eng_d.st = ST_IGNORE;
                end else if (scl_fall) begin
                    eng_d.stretch = 1'b1;
                end
            end
            default: ;
        endcase

        // bus conditions override everything
        late_cond = ((eng_q.st == ST_RX) || (eng_q.st == ST_TX)) && (eng_q.cnt >= LATE_CNT);
        if (start_evt) begin
            if (late_cond) eng_d.berr = 1'b1;
            eng_d.tx      = 1'b0;
            eng_d.lrb     = 1'b0;
            eng_d.bc      = 1'b0;
            eng_d.cnt     = '0;
            eng_d.in_addr = 1'b1;
            eng_d.stretch = 1'b0;
            eng_d.st      = ST_RX;
        end
        if (stop_evt) begin
            if (late_cond) eng_d.berr = 1'b1;
            eng_d.stop    = 1'b1;
            eng_d.stretch = 1'b0;
            eng_d.st      = ST_IDLE;
        end

        // data line: only moves while the clock is low
        drive_want = ((eng_d.st == ST_RXACK) && eng_d.ack) ||
                     ((eng_d.st == ST_TX) && (eng_d.cnt < ACK_SLOT) && !eng_d.dat[BYTE_W-1]);
        if (!scl_s) eng_d.sda_low = drive_want;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            eng_q     <= '0;
            eng_q.st  <= ST_IDLE;
        end else begin
            eng_q <= eng_d;
        end
    end

    assign stat_byte = {eng_q.berr, 1'b0, eng_q.stop, eng_q.ack,
                        eng_q.adr, eng_q.tx, eng_q.lrb, eng_q.bc};

    assign reg_rdata_o = reg_sel_i ? stat_byte : eng_q.dat;
    assign scl_low_o   = eng_q.stretch;
    assign sda_low_o   = eng_q.sda_low;
    assign irq_o       = eng_q.bc | (eng_q.stop & stop_irq_en_i);
endmodule

// File: rtl/i2cs_checker.sv
module i2cs_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       reg_we_i,
    input logic       reg_sel_i,
    input logic       wbit_berr,
    input logic       scl_low_o,
    input logic       sda_low_o,
    input logic       irq_o,
    input logic       scl_sync,
    input logic       start_evt,
    input logic       stop_evt,
    input logic [7:0] stat
);
    // R4: a hold needs a pending byte
    assert_stretch_needs_bc_R4: assert property (@(posedge clk) disable iff (!rst_n)
        scl_low_o |-> stat[0]);

    // R4: a control write lets the clock go
    assert_write_releases_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we_i && reg_sel_i && scl_low_o) |=> !scl_low_o);

    // R6: the data output moves only after the clock was seen low
    assert_sda_moves_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_low_o != $past(sda_low_o)) |-> !$past(scl_sync));

    // R1: start clears the direction and byte flags
    assert_start_clears_R1: assert property (@(posedge clk) disable iff (!rst_n)
        start_evt |=> (stat[2:0] == 3'b000));

    // R9: stop sets stop status
    assert_stop_sets_R9: assert property (@(posedge clk) disable iff (!rst_n)
        stop_evt |=> stat[5]);

    // R10: bus error only leaves through a write of 0
    assert_berr_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (stat[7] && !(reg_we_i && reg_sel_i && !wbit_berr)) |=> stat[7]);

    // R3: ack-out reads 0 whenever a new byte completes
    assert_ack_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat[0]) |-> !stat[4]);

    // R2: a pending byte raises the interrupt
    assert_irq_on_bc_R2: assert property (@(posedge clk) disable iff (!rst_n)
        stat[0] |-> irq_o);
endmodule

bind i2c_byte_slave i2cs_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_we_i  (reg_we_i),
    .reg_sel_i (reg_sel_i),
    .wbit_berr (reg_wdata_i[7]),
    .scl_low_o (scl_low_o),
    .sda_low_o (sda_low_o),
    .irq_o     (irq_o),
    .scl_sync  (scl_s),
    .start_evt (start_evt),
    .stop_evt  (stop_evt),
    .stat      (stat_byte)
);

// File: tb/tb_i2c_byte_slave.sv
module tb_i2c_byte_slave;
    localparam int Q = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_scl = 1'b1, m_sda = 1'b1;
    logic scl_bus, sda_bus;
    logic scl_low_o, sda_low_o, irq_o;
    logic reg_we = 1'b0, reg_sel = 1'b0, stop_ie = 1'b0;
    logic [7:0] reg_wdata = '0, reg_rdata;

    int n_chk = 0, n_err = 0;
    bit done = 0;
    logic [7:0] exp_q[$];
    logic [7:0] rd_val;
    event rd_ev;

    always #10 clk = ~clk;

    assign scl_bus = m_scl & ~scl_low_o;
    assign sda_bus = m_sda & ~sda_low_o;

    i2c_byte_slave #(.SYNC_STAGES(3)) dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_bus), .sda_i(sda_bus),
        .scl_low_o(scl_low_o), .sda_low_o(sda_low_o),
        .reg_we_i(reg_we), .reg_sel_i(reg_sel), .reg_wdata_i(reg_wdata),
        .reg_rdata_o(reg_rdata), .stop_irq_en_i(stop_ie), .irq_o(irq_o)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic q();
        repeat (Q) @(negedge clk);
    endtask

    task automatic sw_write(input logic sel, input logic [7:0] v);
        @(negedge clk);
        reg_we = 1'b1; reg_sel = sel; reg_wdata = v;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic sw_read(input logic sel, output logic [7:0] v);
        @(negedge clk);
        reg_sel = sel;
        #1 v = reg_rdata;
    endtask

    // driver: software loads a transmit byte and records it for the scoreboard
    task automatic sw_load_tx(input logic [7:0] v);
        sw_write(1'b0, v);
        exp_q.push_back(v);
    endtask

    task automatic m_start();
        m_sda = 1'b1; q();
        m_scl = 1'b1; wait (scl_bus); q();
        m_sda = 1'b0; q();
        m_scl = 1'b0; q();
    endtask

    task automatic m_stop();
        m_sda = 1'b0; q();
        m_scl = 1'b1; wait (scl_bus); q();
        m_sda = 1'b1; q();
    endtask

    task automatic m_bit_w(input logic b, input bit early, input logic [7:0] ev);
        m_sda = b; q();
        m_scl = 1'b1; wait (scl_bus); q(); q();
        if (early) sw_write(1'b1, ev);
        m_scl = 1'b0; q();
    endtask

    task automatic m_bit_r(output logic b);
        m_sda = 1'b1; q();
        m_scl = 1'b1; wait (scl_bus); q();
        b = sda_bus; q();
        m_scl = 1'b0; q();
    endtask

    task automatic m_byte_w(input logic [7:0] v, input bit early, input logic [7:0] ev);
        for (int i = 7; i >= 0; i--) m_bit_w(v[i], early && (i == 0), ev);
    endtask

    task automatic m_byte_r();
        logic b;
        logic [7:0] acc;
        acc = '0;
        for (int i = 7; i >= 0; i--) begin
            m_bit_r(b);
            acc[i] = b;
        end
        rd_val = acc;
        -> rd_ev;
    endtask

    // monitor: bytes seen by the master against what software loaded
    initial begin
        forever begin
            @(rd_ev);
            if (exp_q.size() == 0) begin
                n_chk++; n_err++;
                $display("FAIL R6 unexpected byte act=%h exp=none", rd_val);
            end else begin
                chk("R6 transmit byte", rd_val, exp_q.pop_front());
            end
        end
    end

    // R6: slave data output must not move while the clock line is high
    initial begin
        logic prev;
        prev = 1'b0;
        forever begin
            @(negedge clk);
            if (rst_n && (sda_low_o !== prev)) begin
                chk("R6 sda moves with scl low", {7'b0, scl_bus}, 8'h00);
            end
            prev = sda_low_o;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog act=running exp=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        logic b;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // reset state, R10 / R2
        sw_read(1'b1, v); chk("R10 reset status", v, 8'h00);
        sw_read(1'b0, v); chk("R2 reset data", v, 8'h00);
        chk("R4 reset scl", {7'b0, scl_low_o}, 8'h00);
        chk("R2 reset irq", {7'b0, irq_o}, 8'h00);

        // write transfer: address 0xA4 then data 0x5C
        m_start();
        m_byte_w(8'hA4, 1'b0, 8'h00);
        chk("R4 stretch after late answer", {7'b0, scl_low_o}, 8'h01);
        sw_read(1'b1, v); chk("R2 address status", v, 8'h09);
        sw_read(1'b0, v); chk("R2 address byte", v, 8'hA4);
        chk("R2 irq on byte", {7'b0, irq_o}, 8'h01);
        sw_write(1'b1, 8'h10);
        chk("R4 write releases", {7'b0, scl_low_o}, 8'h00);
        m_bit_r(b); chk("R3 ack driven", {7'b0, b}, 8'h00);
        m_byte_w(8'h5C, 1'b0, 8'h00);
        sw_read(1'b1, v); chk("R3 R5 data status", v, 8'h01);
        sw_read(1'b0, v); chk("R5 data byte", v, 8'h5C);
        sw_write(1'b1, 8'h00);
        m_bit_r(b); chk("R3 nack released", {7'b0, b}, 8'h01);
        m_stop();
        sw_read(1'b1, v); chk("R9 stop status", v, 8'h20);
        chk("R9 irq off without enable", {7'b0, irq_o}, 8'h00);
        stop_ie = 1'b1;
        @(negedge clk);
        chk("R9 irq with enable", {7'b0, irq_o}, 8'h01);
        stop_ie = 1'b0;
        sw_write(1'b1, 8'h00);
        sw_read(1'b1, v); chk("R9 clear ignored without bc", v, 8'h20);

        // early answer: no stretch, stop cleared while bc set
        m_start();
        m_byte_w(8'h30, 1'b1, 8'h10);
        chk("R4 no stretch on early answer", {7'b0, scl_low_o}, 8'h00);
        sw_read(1'b1, v); chk("R9 stop cleared with bc", v, 8'h10);
        m_bit_r(b); chk("R3 ack early", {7'b0, b}, 8'h00);
        m_stop();
        sw_read(1'b1, v); chk("R10 no error on stop after ack", v[7:5], 3'b001);

        // read transfer: address 0xA5, two bytes, master NACK at the end
        m_start();
        m_byte_w(8'hA5, 1'b0, 8'h00);
        sw_load_tx(8'hC3);
        sw_write(1'b1, 8'h14);
        m_bit_r(b); chk("R3 ack on read address", {7'b0, b}, 8'h00);
        m_byte_r();
        m_bit_w(1'b0, 1'b0, 8'h00);
        chk("R6 stretch after tx byte", {7'b0, scl_low_o}, 8'h01);
        sw_read(1'b1, v); chk("R6 status after master ack", v[2:0], 3'b101);
        sw_load_tx(8'h6A);
        sw_write(1'b1, 8'h04);
        m_byte_r();
        m_bit_w(1'b1, 1'b0, 8'h00);
        sw_read(1'b1, v); chk("R6 master nack seen", v[2:0], 3'b111);
        sw_write(1'b1, 8'h06);
        chk("R7 released after nack", {7'b0, scl_low_o}, 8'h00);
        m_bit_r(b); chk("R7 sda released", {7'b0, b}, 8'h01);
        m_bit_r(b);
        sw_read(1'b1, v); chk("R7 no byte complete", v[0], 1'b0);
        m_stop();

        // start clears direction and flags
        m_start();
        sw_read(1'b1, v); chk("R1 start clears", v[2:0], 3'b000);

        // software NACKs an address
        m_byte_w(8'h5E, 1'b0, 8'h00);
        sw_write(1'b1, 8'h00);
        m_bit_r(b); chk("R8 address nack", {7'b0, b}, 8'h01);
        m_byte_w(8'h0F, 1'b0, 8'h00);
        sw_read(1'b1, v); chk("R8 no byte complete", v[0], 1'b0);
        chk("R8 no irq", {7'b0, irq_o}, 8'h00);
        chk("R8 no stretch", {7'b0, scl_low_o}, 8'h00);
        m_start();
        m_byte_w(8'h12, 1'b0, 8'h00);
        sw_read(1'b1, v); chk("R8 next address completes", v[3:0], 4'b1001);
        sw_write(1'b1, 8'h10);
        m_bit_r(b);

        // misplaced start: bus error
        m_bit_w(1'b1, 1'b0, 8'h00);
        m_bit_w(1'b0, 1'b0, 8'h00);
        m_bit_w(1'b1, 1'b0, 8'h00);
        m_start();
        sw_read(1'b1, v); chk("R10 bus error set", v[7], 1'b1);
        m_stop();
        sw_read(1'b1, v); chk("R10 hardware keeps error", v[7], 1'b1);
        sw_write(1'b1, 8'h80);
        sw_read(1'b1, v); chk("R10 write 1 keeps error", v[7], 1'b1);
        sw_write(1'b1, 8'h00);
        sw_read(1'b1, v); chk("R10 write 0 clears error", v[7], 1'b0);
        chk("R10 bit 6 reads 0", v[6], 1'b0);

        repeat (20) @(negedge clk);
        chk("R6 scoreboard drained", 8'(exp_q.size()), 8'h00);
        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule